// File: doc/BRIEF.md
# I2C Target Bridge with Acknowledge-Slot Clock Stretching

This block is the local-bus target half of a control-channel bridge. It watches an open-drain I2C bus as a target, collects each byte the master writes, and hands every completed byte to a remote-side interface over a valid/ready handshake. The remote side finishes the real transfer on the far bus. The local master therefore has to wait for the outcome at each acknowledge slot, and the block holds SCL low at the ninth clock of every byte until the remote side reports ACK or NACK.

Once the response arrives, the block releases the lines in a fixed order. On ACK it first pulls SDA low, waits a settling interval counted in system clocks, and only then lets SCL go. It keeps SDA low until the master drives SCL low again. On NACK it leaves SDA released, lets SCL go, and ignores the bus until the next START. The block never produces clock pulses of its own. It only holds the clock low.

The block answers only to one 7-bit address, set by a parameter. Read-data return and 10-bit addressing are not handled. The R/W bit is forwarded as part of the address byte.

Top module: `i2c_stretch_bridge`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new transfer with the next byte treated as the address byte. A STOP (SDA rising while SCL is high) returns the block to idle. Bits clocked after a STOP and without a new START are neither acknowledged nor forwarded.
- R2: The address byte is accepted only when its upper 7 bits equal TARGET_ADDR. A non-matching address is never offered on the byte output, is never stretched, and reads as NACK (SDA high) in its acknowledge slot.
- R3: On the SCL falling edge after the eighth bit of an accepted byte, the block pulls SCL low and raises byte_valid_o. SDA stays released for the whole stretch.
- R4: The stretch lasts until the offered byte has been taken (byte_valid_o with byte_ready_i) and, after that, resp_valid_i is seen. The byte output holds stable while it is not taken.
- R5: On ACK (resp_ack_i = 1) the block pulls SDA low and releases SCL exactly SETTLE clock cycles later, so the master reads 0 in the acknowledge slot.
- R6: After releasing SCL on ACK, the block keeps SDA low for as long as the master holds SCL high. It releases SDA on the next SCL falling edge.
- R7: On NACK (resp_ack_i = 0) SDA stays released through the ninth clock. Every later byte up to the next START reads NACK and is not forwarded.
- R8: byte_data_o carries the received byte with the first bit on the bus in bit 7. byte_first_o is 1 for the address byte and 0 for data bytes.
- R9: The block changes its SDA pull only while the SCL line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| byte_valid_o | output | 1 | A received byte is offered to the remote side |
| byte_ready_i | input | 1 | Remote side takes the offered byte |
| byte_data_o | output | 8 | Offered byte, first bus bit in bit 7 |
| byte_first_o | output | 1 | Offered byte is the address byte |
| resp_valid_i | input | 1 | Remote response is present |
| resp_ack_i | input | 1 | Remote response: 1 ACK, 0 NACK |

## Verification
The bench holds SCL high for a long time after an ACK release, to catch a design that lets SDA go early and so turns the acknowledge into a NACK or a false STOP. It delays byte_ready_i and the response by random amounts. A design that ended the stretch on the response alone, or on the handshake alone, would let the master clock on while SCL should still be held. It counts the cycles between the SDA pull and the SCL release, where a wrong order would show SCL rising with SDA still high in the ACK slot. It also sends NACKs on address and data bytes, mismatched addresses, and bytes after a STOP with no START, each of which would be forwarded or acknowledged by a design that failed to go quiet.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_WAIT_FALL,
        ST_OFFER,
        ST_WAIT_RESP,
        ST_SETTLE,
        ST_PARK
    } br_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    localparam int BYTE_BITS = 8;

    function automatic logic addr_hit(input logic [BYTE_BITS-1:0] b, input logic [6:0] a);
        return b[BYTE_BITS-1:1] == a;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_bridge_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt_o.scl      = scl_s;
        evt_o.sda      = sda_s;
        evt_o.scl_rise = scl_s & ~scl_q;
        evt_o.scl_fall = ~scl_s & scl_q;
        evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_bridge_fsm.sv
module i2c_bridge_fsm
    import i2c_bridge_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2A,
    parameter int         SETTLE      = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_evt_t             evt_i,
    output logic                 scl_pull_o,
    output logic                 sda_pull_o,
    output logic                 byte_valid_o,
    input  logic                 byte_ready_i,
    output logic [BYTE_BITS-1:0] byte_data_o,
    output logic                 byte_first_o,
    input  logic                 resp_valid_i,
    input  logic                 resp_ack_i
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam int BW = $clog2(BYTE_BITS);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE - 1);
    localparam logic [BW-1:0] BIT_LAST    = BW'(BYTE_BITS - 1);

    br_state_e            state;
    logic [BYTE_BITS-1:0] shreg;
    logic [BW-1:0]        bitcnt;
    logic [CW-1:0]        wait_cnt;
    logic                 first;
    logic                 acked;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            shreg        <= '0;
            bitcnt       <= '0;
            wait_cnt     <= '0;
            first        <= 1'b1;
            acked        <= 1'b0;
            scl_pull_o   <= 1'b0;
            sda_pull_o   <= 1'b0;
            byte_valid_o <= 1'b0;
        end else if (evt_i.stop || evt_i.start) begin
            state        <= evt_i.start ? ST_RECV : ST_IDLE;
            bitcnt       <= '0;
            first        <= 1'b1;
            scl_pull_o   <= 1'b0;
            sda_pull_o   <= 1'b0;
            byte_valid_o <= 1'b0;
        end else begin
            unique case (state)
                ST_RECV: if (evt_i.scl_rise) begin
                    shreg <= {shreg[BYTE_BITS-2:0], evt_i.sda};
                    if (bitcnt == BIT_LAST) begin
                        bitcnt <= '0;
                        state  <= ST_WAIT_FALL;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_WAIT_FALL: if (evt_i.scl_fall) begin
                    if (first && !addr_hit(shreg, TARGET_ADDR)) begin
                        state <= ST_IDLE;
                    end else begin
                        scl_pull_o   <= 1'b1;
                        byte_valid_o <= 1'b1;
                        state        <= ST_OFFER;
                    end
                end
                ST_OFFER: if (byte_ready_i) begin
                    byte_valid_o <= 1'b0;
                    state        <= ST_WAIT_RESP;
                end
                ST_WAIT_RESP: if (resp_valid_i) begin
                    acked <= resp_ack_i;
                    if (resp_ack_i) begin
                        sda_pull_o <= 1'b1;
                        wait_cnt   <= '0;
                        state      <= ST_SETTLE;
                    end else begin
                        scl_pull_o <= 1'b0;
                        state      <= ST_PARK;
                    end
                end
                ST_SETTLE: begin
                    if (wait_cnt == SETTLE_LAST) begin
                        scl_pull_o <= 1'b0;
                        state      <= ST_PARK;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_PARK: if (evt_i.scl_fall) begin
                    sda_pull_o <= 1'b0;
                    first      <= 1'b0;
                    state      <= acked ? ST_RECV : ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign byte_data_o  = shreg;
    assign byte_first_o = first;
endmodule

// File: rtl/i2c_stretch_bridge.sv
module i2c_stretch_bridge
    import i2c_bridge_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2A,
    parameter int         SETTLE      = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pull_o,
    output logic       sda_pull_o,
    output logic       byte_valid_o,
    input  logic       byte_ready_i,
    output logic [7:0] byte_data_o,
    output logic       byte_first_o,
    input  logic       resp_valid_i,
    input  logic       resp_ack_i
);
    logic     scl_s, sda_s;
    bus_evt_t evt;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .d_i(scl_i), .q_o(scl_s)
    );
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .d_i(sda_i), .q_o(sda_s)
    );

    i2c_cond_detect u_detect (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .evt_o(evt)
    );

    i2c_bridge_fsm #(.TARGET_ADDR(TARGET_ADDR), .SETTLE(SETTLE)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .scl_pull_o   (scl_pull_o),
        .sda_pull_o   (sda_pull_o),
        .byte_valid_o (byte_valid_o),
        .byte_ready_i (byte_ready_i),
        .byte_data_o  (byte_data_o),
        .byte_first_o (byte_first_o),
        .resp_valid_i (resp_valid_i),
        .resp_ack_i   (resp_ack_i)
    );
endmodule

// File: rtl/i2c_stretch_bridge_chk.sv
module i2c_stretch_bridge_chk #(
    parameter int SETTLE = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       scl_pull_o,
    input logic       sda_pull_o,
    input logic       byte_valid_o,
    input logic       byte_ready_i,
    input logic [7:0] byte_data_o
);
    int both_cnt;

    always_ff @(posedge clk) begin
        if (rst)                          both_cnt <= 0;
        else if (scl_pull_o && sda_pull_o) both_cnt <= both_cnt + 1;
        else                              both_cnt <= 0;
    end

    // R3
    offer_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> (scl_pull_o && !sda_pull_o));

    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

    // R5
    settle_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_pull_o) && sda_pull_o) |-> (both_cnt == SETTLE));

    // R6
    park_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o && !scl_pull_o && scl_i) |=> sda_pull_o);

    // R9
    sda_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind i2c_stretch_bridge i2c_stretch_bridge_chk #(.SETTLE(SETTLE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_i),
    .scl_pull_o   (scl_pull_o),
    .sda_pull_o   (sda_pull_o),
    .byte_valid_o (byte_valid_o),
    .byte_ready_i (byte_ready_i),
    .byte_data_o  (byte_data_o)
);

// File: tb/i2c_stretch_bridge_bench.sv
module i2c_stretch_bridge_bench;
    localparam logic [6:0] ADDR   = 7'h2A;
    localparam int         SETTLE = 4;
    localparam int         T      = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_pull, sda_pull, byte_valid, byte_first;
    logic byte_ready = 1'b0, resp_valid = 1'b0, resp_ack = 1'b0;
    logic [7:0] byte_data;
    wire scl_line = scl_m & ~scl_pull;
    wire sda_line = sda_m & ~sda_pull;

    int checks = 0, errors = 0, cycles = 0;
    int rx_idx = 0, nack_at = 0, ready_dly = 0, resp_dly = 0;
    int both_cnt = 0, last_settle = -1;
    logic [7:0] fwd_q[$];
    logic       first_q[$];
    logic       sda_pull_prev = 1'b0;

    always #4 clk = ~clk;

    i2c_stretch_bridge #(.TARGET_ADDR(ADDR), .SETTLE(SETTLE), .SYNC_STAGES(2)) u_i2c_stretch_bridge (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
        .byte_valid_o(byte_valid), .byte_ready_i(byte_ready),
        .byte_data_o(byte_data), .byte_first_o(byte_first),
        .resp_valid_i(resp_valid), .resp_ack_i(resp_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    function automatic bit exp_ack_bit(input bit match, input int idx, input int nk);
        return !(match && idx < nk);
    endfunction

    // settle-interval monitor and SDA-change monitor
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if (scl_pull && sda_pull) both_cnt++;
            else begin
                if (!scl_pull && sda_pull && both_cnt > 0) last_settle = both_cnt;
                both_cnt = 0;
            end
            if (sda_pull != sda_pull_prev) chk(!scl_line, "R9 sda pull changed with scl high", scl_line, 0);
            sda_pull_prev = sda_pull;
        end
    end

    // remote-side model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && byte_valid) begin
                fwd_q.push_back(byte_data);
                first_q.push_back(byte_first);
                chk(scl_pull && !sda_pull, "R3 stretch with sda released", {scl_pull, sda_pull}, 2);
                repeat (ready_dly) begin
                    @(negedge clk);
                    chk(scl_pull && byte_valid, "R4 held before accept", {scl_pull, byte_valid}, 3);
                end
                byte_ready = 1'b1;
                @(negedge clk);
                byte_ready = 1'b0;
                repeat (resp_dly) begin
                    @(negedge clk);
                    chk(scl_pull && !sda_pull, "R4 held before response", {scl_pull, sda_pull}, 2);
                end
                resp_valid = 1'b1;
                resp_ack   = (rx_idx != nack_at);
                rx_idx++;
                @(negedge clk);
                resp_valid = 1'b0;
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(T); scl_m = 1'b1; wait_high(); wait_clk(T);
        sda_m = 1'b0; wait_clk(T); scl_m = 1'b0; wait_clk(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(T); scl_m = 1'b1; wait_high(); wait_clk(T);
        sda_m = 1'b1; wait_clk(T);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp, input bit hold_long, input string req);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(T);
            scl_m = 1'b1; wait_high(); wait_clk(T);
            scl_m = 1'b0; wait_clk(T);
        end
        last_settle = -1;
        sda_m = 1'b1; wait_clk(T);
        scl_m = 1'b1; wait_high(); wait_clk(T);
        got = sda_line;
        if (hold_long) begin
            wait_clk(200);
            chk(sda_line == got, "R6 sda held while scl high", sda_line, got);
        end
        scl_m = 1'b0; wait_clk(T);
        chk(got == exp, req, got, exp);
        chk(!sda_pull, "R6 sda released after scl fall", sda_pull, 0);
        if (!exp) chk(last_settle == SETTLE, "R5 settle cycles", last_settle, SETTLE);
    endtask

    task automatic run_txn(input logic [6:0] a, input bit rw, input int n, input int nk, input int long_idx);
        logic [7:0] bytes[$];
        bit match = (a == ADDR);
        int exp_n;
        bytes.push_back({a, rw});
        for (int k = 0; k < n; k++) bytes.push_back(8'($urandom));
        fwd_q.delete(); first_q.delete();
        rx_idx = 0; nack_at = nk;
        bus_start();
        for (int k = 0; k <= n; k++) begin
            send_byte(bytes[k], exp_ack_bit(match, k, nk), k == long_idx,
                      !match ? "R2 mismatch nack" : (k < nk ? "R5 ack bit" : "R7 nack bit"));
        end
        bus_stop();
        exp_n = !match ? 0 : ((n + 1 < nk + 1) ? n + 1 : nk + 1);
        chk(fwd_q.size() == exp_n, match ? "R7 forwarded count" : "R2 forwarded count", fwd_q.size(), exp_n);
        for (int k = 0; k < fwd_q.size() && k < exp_n; k++) begin
            chk(fwd_q[k] == bytes[k], "R8 byte value", fwd_q[k], bytes[k]);
            chk(first_q[k] == (k == 0), "R8 first flag", first_q[k], k == 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_clk(5);
        chk(!scl_pull && !sda_pull && !byte_valid, "R1 reset state", {scl_pull, sda_pull, byte_valid}, 0);
        rst = 1'b0;
        wait_clk(10);

        ready_dly = 3; resp_dly = 5;
        run_txn(ADDR, 1'b0, 3, 99, -1);           // R5 all acked
        run_txn(7'h15, 1'b0, 2, 99, -1);          // R2 wrong address
        run_txn(ADDR, 1'b0, 3, 0, -1);            // R7 nack on address
        run_txn(ADDR, 1'b1, 3, 2, -1);            // R7 nack on data byte
        ready_dly = 40; resp_dly = 60;
        run_txn(ADDR, 1'b0, 2, 99, 1);            // R4 long waits, R6 long park
        ready_dly = 0; resp_dly = 0;
        run_txn(ADDR, 1'b0, 1, 99, 0);

        // R1: bits after STOP with no START are ignored
        fwd_q.delete();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, "R1 no ack after stop");
        chk(fwd_q.size() == 0, "R1 nothing forwarded after stop", fwd_q.size(), 0);
        bus_stop();

        for (int t = 0; t < 30; t++) begin
            logic [6:0] a;
            a = ($urandom % 2) ? ADDR : 7'($urandom);
            ready_dly = $urandom % 8;
            resp_dly  = $urandom % 8;
            run_txn(a, 1'($urandom), 1 + $urandom % 4, $urandom % 6,
                    ($urandom % 4 == 0) ? int'($urandom % 3) : -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        checks++; errors++;
        $display("FAIL R4 watchdog expired: actual %0d expected %0d", cycles, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule